// File: doc/BRIEF.md
# Reversible Cascade Online Parity Checker

This block models a cascade of multiple-control Toffoli gates acting on a small set of data lines. The cascade is widened by one extra parity line so that faults can be caught while the circuit is running. Each gate is held in registers as a control mask and a target line index, and is written through a configuration port. Gates are evaluated strictly in index order. A gate whose mask is empty flips its target line unconditionally. A gate that has never been written passes its inputs through unchanged.

Around the cascade the block builds a testable form of it. An entry fan folds every data line into the parity line. After each gate comes a copy gate with the same controls, aimed at the parity line. An exit fan folds every data line into the parity line again. When the circuit is fault-free, the parity line leaves exactly as it entered, and the data outputs are those of the plain cascade.

A fault port can move one control of one gate onto a line that is neither a control nor that gate's target. The fault touches only the data gate and never its copy. When the moved control and the original control disagree for some vector, the parity bit comes out inverted. On an apply strobe, the block registers an error flag that records this inversion, together with a one-cycle valid strobe.

Top module: `rev_parity_checker`

## Requirements
- R1: After reset every gate is the identity, `data_out` equals `vec_in`, `aux_out` equals `aux_in`, and `err_flag`, `result_valid` and `config_error` are 0.
- R2: An accepted write stores a control mask (bit i = line i) and a target index for one gate. That gate then inverts its target line exactly when all masked lines are 1. An empty mask inverts the target line unconditionally.
- R3: A write whose mask has the target line's bit set, or whose target or gate index is out of range, is rejected. The gate keeps its previous setting and `config_error` becomes 1 in the next cycle. An accepted write clears `config_error` in the next cycle, and `config_error` does not change without a write.
- R4: With no fault requested, `aux_out` equals `aux_in` for every vector and every configuration.
- R5: `result_valid` is 1 in the cycle after each cycle in which `apply` is 1, and 0 otherwise.
- R6: When `result_valid` is 1, `err_flag` equals `aux_out XOR aux_in` as it stood in the `apply` cycle, so it is 0 for a fault-free cascade.
- R7: A valid fault request moves control `flt_from` of gate `flt_gate` to line `flt_to`, and `data_out` follows the altered gate. A vector with 0 on the old control line, 1 on the new one and 1 on the remaining controls inverts `aux_out` and raises `err_flag`.
- R8: A fault request is ignored, and both outputs keep their fault-free values, when `flt_from` is not a control of the chosen gate, or when `flt_to` is already a control or is that gate's target.
- R9: Gates take effect in index order 0 to G-1. Each gate sees the data lines as left by the gates before it.
- R10: Under a valid fault, a vector for which the old and new control sets give the same firing decision leaves `aux_out` equal to `aux_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Gate configuration write strobe |
| cfg_gate | input | GW | Index of the gate to write |
| cfg_mask | input | N_LINES | Control mask, bit i selects line i |
| cfg_target | input | TW | Target line index |
| flt_en | input | 1 | Fault request enable |
| flt_gate | input | GW | Gate that receives the fault |
| flt_from | input | TW | Control line that is moved |
| flt_to | input | TW | Line the control moves to |
| apply | input | 1 | Capture strobe for the error flag |
| vec_in | input | N_LINES | Data input vector |
| aux_in | input | 1 | Parity line input |
| data_out | output | N_LINES | Data lines after the cascade |
| aux_out | output | 1 | Parity line after the exit fan |
| err_flag | output | 1 | Registered parity inversion flag |
| result_valid | output | 1 | One-cycle strobe after apply |
| config_error | output | 1 | Last configuration write was rejected |

## Verification
The properties assume that all inputs hold steady across each rising edge, and that the fault and configuration ports never carry unknown values while reset is released. The bench drives everything on the falling edge and keeps every field defined. The fault-free parity property assumes that a fault is asserted only while `flt_en` is high. The stimulus therefore raises `flt_en` only inside the fault scenarios and drops it before returning to fault-free checks.

// File: rtl/rpc_pkg.sv
// Package: shared limits and helper functions for the reversible
// cascade parity checker. Assumes no configuration exceeds MAX_LINES.
package rpc_pkg;

    localparam int MAX_LINES = 8;
    localparam int MAX_GATES = 16;

    // A gate fires when every masked line is 1 (empty mask always fires).
    function automatic logic gate_fires(input logic [MAX_LINES-1:0] lines,
                                        input logic [MAX_LINES-1:0] mask);
        return &(lines | ~mask);
    endfunction

    // Odd parity of a zero-extended line vector.
    function automatic logic line_parity(input logic [MAX_LINES-1:0] lines);
        return ^lines;
    endfunction

endpackage

// File: rtl/rpc_cfg_regs.sv
// Module: per-gate configuration registers. Accepts a write only when the
// gate index and target lie in range and the target is not among the
// controls; otherwise it keeps the old setting and raises config_error.
// Assumes synchronous active-low reset, all gates disabled after reset.
module rpc_cfg_regs #(
    parameter int N_LINES = 4,
    parameter int N_GATES = 4,
    localparam int TW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int GW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [GW-1:0]                   cfg_gate,
    input  logic [N_LINES-1:0]              cfg_mask,
    input  logic [TW-1:0]                   cfg_target,
    output logic [N_GATES-1:0][N_LINES-1:0] gate_mask,
    output logic [N_GATES-1:0][TW-1:0]      gate_tgt,
    output logic [N_GATES-1:0]              gate_on,
    output logic                            config_error
);

    logic [N_LINES-1:0] tgt_oh;
    logic               tgt_in_range;
    logic               gate_in_range;
    logic               write_ok;

    // Decode the requested target line to one-hot.
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            tgt_oh[i] = (cfg_target == TW'(i));
        end
    end

    // Legality of the incoming write.
    always_comb begin
        tgt_in_range  = |tgt_oh;
        gate_in_range = (int'(cfg_gate) < N_GATES);
        write_ok      = tgt_in_range && gate_in_range && ((cfg_mask & tgt_oh) == '0);
    end

    // Result of the most recent write attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            config_error <= 1'b0;
        end else if (cfg_we) begin
            config_error <= !write_ok;
        end
    end

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        // Store one gate's mask, target and enable on an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gate_mask[g] <= '0;
                gate_tgt[g]  <= '0;
                gate_on[g]   <= 1'b0;
            end else if (cfg_we && write_ok && (int'(cfg_gate) == g)) begin
                gate_mask[g] <= cfg_mask;
                gate_tgt[g]  <= cfg_target;
                gate_on[g]   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rpc_fault_map.sv
// Module: builds the effective control mask of each data gate. A fault
// request moves one existing control to a line that is neither a control
// nor the target; any other request leaves every mask untouched.
// Assumes the stored masks never contain their own target line.
module rpc_fault_map #(
    parameter int N_LINES = 4,
    parameter int N_GATES = 4,
    localparam int TW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int GW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
    input  logic [N_GATES-1:0][N_LINES-1:0] gate_mask,
    input  logic [N_GATES-1:0][TW-1:0]      gate_tgt,
    input  logic [N_GATES-1:0]              gate_on,
    input  logic                            flt_en,
    input  logic [GW-1:0]                   flt_gate,
    input  logic [TW-1:0]                   flt_from,
    input  logic [TW-1:0]                   flt_to,
    output logic [N_GATES-1:0][N_LINES-1:0] eff_mask
);

    logic [N_LINES-1:0] from_oh;
    logic [N_LINES-1:0] to_oh;

    // One-hot decode of the moved-from and moved-to lines.
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            from_oh[i] = (flt_from == TW'(i));
            to_oh[i]   = (flt_to == TW'(i));
        end
    end

    for (genvar g = 0; g < N_GATES; g++) begin : g_map
        logic [N_LINES-1:0] own_tgt_oh;
        logic               moves;

        // Decode this gate's target line.
        always_comb begin
            for (int i = 0; i < N_LINES; i++) begin
                own_tgt_oh[i] = (gate_tgt[g] == TW'(i));
            end
        end

        // Decide whether the request is a legal displacement for this gate.
        always_comb begin
            moves = flt_en && gate_on[g] && (int'(flt_gate) == g)
                 && ((gate_mask[g] & from_oh) != '0)
                 && ((gate_mask[g] & to_oh) == '0)
                 && ((own_tgt_oh & to_oh) == '0)
                 && (to_oh != '0);
        end

        // Apply the displacement to the data gate's mask.
        always_comb begin
            eff_mask[g] = moves ? ((gate_mask[g] & ~from_oh) | to_oh) : gate_mask[g];
        end
    end

endmodule

// File: rtl/rpc_stage.sv
// Module: one cascade position, a copy gate on the parity line followed
// by the (possibly faulty) data gate. The copy uses the stored mask, the
// data gate uses the effective mask. A disabled stage is the identity.
// Assumes the stored mask excludes the target, so the copy and the data
// gate see identical control values whatever their order.
module rpc_stage #(
    parameter int N_LINES = 4,
    localparam int TW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] st_in,
    input  logic               par_in,
    input  logic               on,
    input  logic [N_LINES-1:0] mask,
    input  logic [N_LINES-1:0] fmask,
    input  logic [TW-1:0]      tgt,
    output logic [N_LINES-1:0] st_out,
    output logic               par_out
);
    import rpc_pkg::*;

    logic [N_LINES-1:0] tgt_oh;
    logic               copy_fire;
    logic               data_fire;

    // Target decode and firing decisions for both gates.
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            tgt_oh[i] = (tgt == TW'(i));
        end
        copy_fire = on && gate_fires(MAX_LINES'(st_in), MAX_LINES'(mask));
        data_fire = on && gate_fires(MAX_LINES'(st_in), MAX_LINES'(fmask));
    end

    // Update the parity line and the data lines.
    always_comb begin
        par_out = par_in ^ copy_fire;
        st_out  = st_in ^ (tgt_oh & {N_LINES{data_fire}});
    end

endmodule

// File: rtl/rev_parity_checker.sv
// Module: top of the online parity checker. Wraps the configured gate
// cascade with entry and exit parity fans and one copy gate per position,
// so a displaced control shows up as an inverted parity output. Data and
// parity outputs are combinational; the error flag and its valid strobe
// are registered one cycle after apply.
// Assumes N_LINES <= 8 and N_GATES <= 16; synchronous active-low reset.
module rev_parity_checker #(
    parameter int N_LINES = 4,
    parameter int N_GATES = 4,
    localparam int TW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int GW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [GW-1:0]      cfg_gate,
    input  logic [N_LINES-1:0] cfg_mask,
    input  logic [TW-1:0]      cfg_target,
    input  logic               flt_en,
    input  logic [GW-1:0]      flt_gate,
    input  logic [TW-1:0]      flt_from,
    input  logic [TW-1:0]      flt_to,
    input  logic               apply,
    input  logic [N_LINES-1:0] vec_in,
    input  logic               aux_in,
    output logic [N_LINES-1:0] data_out,
    output logic               aux_out,
    output logic               err_flag,
    output logic               result_valid,
    output logic               config_error
);
    import rpc_pkg::*;

    logic [N_GATES-1:0][N_LINES-1:0] gate_mask;
    logic [N_GATES-1:0][TW-1:0]      gate_tgt;
    logic [N_GATES-1:0]              gate_on;
    logic [N_GATES-1:0][N_LINES-1:0] eff_mask;
    logic [N_GATES:0][N_LINES-1:0]   st;
    logic [N_GATES:0]                par;

    rpc_cfg_regs #(.N_LINES(N_LINES), .N_GATES(N_GATES)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_gate     (cfg_gate),
        .cfg_mask     (cfg_mask),
        .cfg_target   (cfg_target),
        .gate_mask    (gate_mask),
        .gate_tgt     (gate_tgt),
        .gate_on      (gate_on),
        .config_error (config_error)
    );

    rpc_fault_map #(.N_LINES(N_LINES), .N_GATES(N_GATES)) u_fmap (
        .gate_mask (gate_mask),
        .gate_tgt  (gate_tgt),
        .gate_on   (gate_on),
        .flt_en    (flt_en),
        .flt_gate  (flt_gate),
        .flt_from  (flt_from),
        .flt_to    (flt_to),
        .eff_mask  (eff_mask)
    );

    // Entry fan: fold every data line into the parity line.
    always_comb begin
        st[0]  = vec_in;
        par[0] = aux_in ^ line_parity(MAX_LINES'(vec_in));
    end

    for (genvar g = 0; g < N_GATES; g++) begin : g_chain
        rpc_stage #(.N_LINES(N_LINES)) u_stage (
            .st_in   (st[g]),
            .par_in  (par[g]),
            .on      (gate_on[g]),
            .mask    (gate_mask[g]),
            .fmask   (eff_mask[g]),
            .tgt     (gate_tgt[g]),
            .st_out  (st[g+1]),
            .par_out (par[g+1])
        );
    end

    // Exit fan: fold the final data lines into the parity line again.
    always_comb begin
        data_out = st[N_GATES];
        aux_out  = par[N_GATES] ^ line_parity(MAX_LINES'(st[N_GATES]));
    end

    // Capture the parity comparison one cycle after apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag     <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= apply;
            err_flag     <= apply && (aux_out != aux_in);
        end
    end

endmodule

// File: rtl/rpc_checker.sv
// Module: property checker for the parity checker, attached by bind.
// Assumes inputs are stable across each rising clock edge.
module rpc_checker #(
    parameter int N_LINES = 4,
    parameter int N_GATES = 4,
    localparam int TW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int GW = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [GW-1:0]      cfg_gate,
    input logic [N_LINES-1:0] cfg_mask,
    input logic [TW-1:0]      cfg_target,
    input logic               flt_en,
    input logic               apply,
    input logic               aux_in,
    input logic               aux_out,
    input logic               err_flag,
    input logic               result_valid,
    input logic               config_error
);

    logic good_write;
    assign good_write = (int'(cfg_target) < N_LINES) && (int'(cfg_gate) < N_GATES)
                     && !cfg_mask[cfg_target];

    // R4
    fault_free_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |-> (aux_out == aux_in));

    // R5
    valid_follows_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> result_valid);

    // R5
    valid_only_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> !result_valid);

    // R6
    err_matches_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (err_flag == $past(aux_out ^ aux_in)));

    // R6
    no_err_without_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !flt_en) |=> !err_flag);

    // R3
    reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !good_write) |=> config_error);

    // R3
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && good_write) |=> !config_error);

    // R3
    cfg_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(config_error));

endmodule

bind rev_parity_checker rpc_checker #(.N_LINES(N_LINES), .N_GATES(N_GATES)) u_rpc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_gate     (cfg_gate),
    .cfg_mask     (cfg_mask),
    .cfg_target   (cfg_target),
    .flt_en       (flt_en),
    .apply        (apply),
    .aux_in       (aux_in),
    .aux_out      (aux_out),
    .err_flag     (err_flag),
    .result_valid (result_valid),
    .config_error (config_error)
);

// File: tb/rev_parity_checker_bench.sv
// Directed bench: four lines, four gates. Cascade used throughout:
// g0 ctrl{0} tgt 1, g1 ctrl{1,2} tgt 0, g2 ctrl{0} tgt 2, g3 ctrl{} tgt 3.
module rev_parity_checker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_gate = '0;
    logic [3:0] cfg_mask = '0;
    logic [1:0] cfg_target = '0;
    logic       flt_en = 1'b0;
    logic [1:0] flt_gate = '0;
    logic [1:0] flt_from = '0;
    logic [1:0] flt_to = '0;
    logic       apply = 1'b0;
    logic [3:0] vec_in = '0;
    logic       aux_in = 1'b0;
    logic [3:0] data_out;
    logic       aux_out;
    logic       err_flag;
    logic       result_valid;
    logic       config_error;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rev_parity_checker u_rev_parity_checker (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_gate (cfg_gate), .cfg_mask (cfg_mask), .cfg_target (cfg_target),
        .flt_en (flt_en), .flt_gate (flt_gate), .flt_from (flt_from), .flt_to (flt_to),
        .apply (apply), .vec_in (vec_in), .aux_in (aux_in),
        .data_out (data_out), .aux_out (aux_out), .err_flag (err_flag),
        .result_valid (result_valid), .config_error (config_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_gate(input logic [1:0] g, input logic [3:0] m, input logic [1:0] t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_gate = g; cfg_mask = m; cfg_target = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_vec(input logic [3:0] v, input logic a);
        @(negedge clk);
        vec_in = v; aux_in = a;
        #1;
    endtask

    // Pulse apply and return in the cycle where result_valid should be high.
    task automatic pulse_apply();
        @(negedge clk);
        apply = 1'b1;
        @(negedge clk);
        apply = 1'b0;
    endtask

    task automatic t_reset();
        set_vec(4'b1010, 1'b1);
        check("R1 data passthrough", 32'(data_out), 32'h a);
        check("R1 aux passthrough", 32'(aux_out), 32'h1);
        check("R1 err_flag", 32'(err_flag), 32'h0);
        check("R1 result_valid", 32'(result_valid), 32'h0);
        check("R1 config_error", 32'(config_error), 32'h0);
    endtask

    task automatic t_configure();
        write_gate(2'd0, 4'b0001, 2'd1);
        write_gate(2'd1, 4'b0110, 2'd0);
        write_gate(2'd2, 4'b0001, 2'd2);
        write_gate(2'd3, 4'b0000, 2'd3);
        check("R3 accepted write clears error", 32'(config_error), 32'h0);
        set_vec(4'b0001, 1'b0);
        check("R2 vec 0001", 32'(data_out), 32'h f);
        set_vec(4'b0000, 1'b0);
        check("R2 empty mask inverts", 32'(data_out), 32'h8);
        set_vec(4'b0110, 1'b1);
        check("R9 gate order vec 0110", 32'(data_out), 32'h b);
    endtask

    task automatic t_parity_sweep();
        for (int v = 0; v < 16; v++) begin
            for (int a = 0; a < 2; a++) begin
                set_vec(4'(v), 1'(a));
                check("R4 fault-free parity", 32'(aux_out), 32'(a));
            end
        end
    endtask

    task automatic t_strobe();
        set_vec(4'b0110, 1'b1);
        pulse_apply();
        check("R5 valid after apply", 32'(result_valid), 32'h1);
        check("R6 no error fault-free", 32'(err_flag), 32'h0);
        @(negedge clk);
        check("R5 valid lasts one cycle", 32'(result_valid), 32'h0);
    endtask

    task automatic t_reject();
        write_gate(2'd2, 4'b0100, 2'd2);
        check("R3 reject flags error", 32'(config_error), 32'h1);
        set_vec(4'b0001, 1'b0);
        check("R3 rejected write keeps gate", 32'(data_out), 32'h f);
        repeat (2) @(negedge clk);
        check("R3 error holds without write", 32'(config_error), 32'h1);
        write_gate(2'd2, 4'b0001, 2'd2);
        check("R3 good write clears error", 32'(config_error), 32'h0);
    endtask

    task automatic t_fault_detect();
        @(negedge clk);
        flt_en = 1'b1; flt_gate = 2'd1; flt_from = 2'd2; flt_to = 2'd3;
        set_vec(4'b1010, 1'b0);
        check("R7 faulty data", 32'(data_out), 32'h7);
        check("R7 aux inverted", 32'(aux_out), 32'h1);
        pulse_apply();
        check("R7 valid", 32'(result_valid), 32'h1);
        check("R7 err_flag raised", 32'(err_flag), 32'h1);
        set_vec(4'b1110, 1'b1);
        check("R10 same-decision vector data", 32'(data_out), 32'h3);
        check("R10 same-decision vector aux", 32'(aux_out), 32'h1);
        pulse_apply();
        check("R10 err_flag low", 32'(err_flag), 32'h0);
        @(negedge clk);
        flt_en = 1'b0;
    endtask

    task automatic t_fault_ignored();
        @(negedge clk);
        flt_en = 1'b1; flt_gate = 2'd1; flt_from = 2'd0; flt_to = 2'd3;
        set_vec(4'b1010, 1'b0);
        check("R8 non-control source data", 32'(data_out), 32'h2);
        check("R8 non-control source aux", 32'(aux_out), 32'h0);
        @(negedge clk);
        flt_from = 2'd1; flt_to = 2'd0;
        set_vec(4'b1010, 1'b1);
        check("R8 onto target data", 32'(data_out), 32'h2);
        check("R8 onto target aux", 32'(aux_out), 32'h1);
        @(negedge clk);
        flt_from = 2'd1; flt_to = 2'd2;
        set_vec(4'b0110, 1'b0);
        check("R8 onto control data", 32'(data_out), 32'h b);
        check("R8 onto control aux", 32'(aux_out), 32'h0);
        pulse_apply();
        check("R8 err_flag low", 32'(err_flag), 32'h0);
        @(negedge clk);
        flt_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_configure();
        t_parity_sweep();
        t_strobe();
        t_reject();
        t_fault_detect();
        t_fault_ignored();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule